// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, once per frame, whether the frame is kept or dropped based on its destination address. The frame arrives as a byte stream, qualified by a valid strobe, with the first byte marked by a start flag and the last byte marked by an end flag. The first six bytes form the destination address, and the first byte is the first one received on the wire.

Four sources can produce an address hit. Two are programmable station addresses and one is the all-ones broadcast address, each gated by its own enable bit. The fourth is a 64-entry group table that is indexed by a 6-bit hash folded from the full address. Hashing and comparison advance one byte at a time, so the address is never buffered. An address verdict comes out one cycle after the sixth byte. A final keep/drop decision comes out one cycle after the last byte, together with the length to hand onward. That length includes four extra bytes that stand for the CRC.

Top module: `rx_addr_filter`

## Requirements
- R1: When enable bit 0 is set, an address equal to station address 0 is a hit. With the bit clear, that equality alone does not produce a hit. Address byte k is held in bits [8k+7:8k] of each station and address value.
- R2: When enable bit 1 is set, an address equal to station address 1 is a hit. With the bit clear, that equality alone does not produce a hit.
- R3: When enable bit 3 is set, the address FF:FF:FF:FF:FF:FF is a hit. With the bit clear, broadcast alone does not produce a hit.
- R4: The hash is the XOR of the eight 6-bit fields A[5:0], A[11:6] and so on up to A[47:42] of the 48-bit address A, where A[0] is bit 0 of the first byte. Table bit h is the entry for hash h (bits 0–31 form the low word and bits 32–63 the high word). A set entry is a hit.
- R5: When enable bit 2 is clear and bit 0 of the first address byte is 0, the table lookup never hits. When enable bit 2 is set, or when that address bit is 1, the lookup follows R4.
- R6: A frame whose address produces no hit from R1–R5 is dropped.
- R7: `addr_valid` is cleared in the cycle after a start byte. It rises in the cycle after the sixth byte, and `addr_hit` rises with it when the address hits. Both then hold until the next start byte. All outputs are 0 after reset.
- R8: A frame of fewer than 12 bytes is dropped, whatever its address. A 12-byte frame with a hitting address is accepted.
- R9: `frame_done` pulses for one cycle, in the cycle after the end byte. In that cycle `frame_accept` gives the decision, and `frame_len` is the byte count plus 4 when the frame is accepted, or 0 when it is dropped.
- R10: Idle cycles (`in_valid` low) between the bytes of a frame leave every verdict unchanged and leave the address outputs stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_eof | input | 1 | Current byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_rx_en | input | 4 | Enables: bit0 station 0, bit1 station 1, bit2 hash on individual addresses, bit3 broadcast |
| cfg_sta0 | input | 48 | Station address 0, byte k at bits [8k+7:8k] |
| cfg_sta1 | input | 48 | Station address 1, same layout |
| cfg_grp_tbl | input | 2**HASH_W | Group hash table, bit h is the entry for hash h |
| addr_valid | output | 1 | Address verdict is present |
| addr_hit | output | 1 | Address verdict: hit |
| frame_done | output | 1 | One-cycle end-of-frame decision strobe |
| frame_accept | output | 1 | Frame kept (valid with frame_done) |
| frame_len | output | LEN_W+1 | Forwarded length including the 4 CRC bytes, 0 when dropped |

## Verification
The hardest condition to reach from the ports is a hit on one particular table entry, because the 6-bit index is a fold of all 48 address bits. The bench builds such an address directly. It fixes the upper 42 bits, XORs their seven fields together, and then chooses the lowest field so that the fold lands on the wanted index. Every index from 0 to 63 is driven this way, once against a one-hot table and once against its complement, with the multicast bit forced both ways through the choice of index. Stalls inside the address bytes are added so that the byte-by-byte accumulation is checked across idle cycles.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int EN_W       = 4;
  // enable bit positions, visible to software
  localparam int EN_STA0    = 0;
  localparam int EN_STA1    = 1;
  localparam int EN_HASHIND = 2;
  localparam int EN_BCAST   = 3;
  localparam int NCMP       = 3;
endpackage

// File: rtl/rx_af_len.sv
module rx_af_len #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic [LEN_W-1:0] pos,
  output logic [LEN_W-1:0] len_nx
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] cnt_q;

  assign pos    = in_sof ? '0 : cnt_q;
  assign len_nx = (pos == LEN_MAX) ? LEN_MAX : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (in_valid)
      cnt_q <= len_nx;
  end
endmodule

// File: rtl/rx_af_hash.sv
module rx_af_hash #(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              first,
  input  logic [2:0]        byte_idx,
  input  logic [7:0]        din,
  output logic [HASH_W-1:0] hash_nx
);
  logic [HASH_W-1:0] hash_q;
  logic [HASH_W-1:0] contrib;

  // each address bit lands on field position (bit index mod HASH_W)
  always_comb begin
    contrib = '0;
    for (int b = 0; b < 8; b++)
      contrib[(8 * int'(byte_idx) + b) % HASH_W] ^= din[b];
  end

  assign hash_nx = (first ? '0 : hash_q) ^ contrib;

  always_ff @(posedge clk) begin
    if (rst)
      hash_q <= '0;
    else if (step)
      hash_q <= hash_nx;
  end
endmodule

// File: rtl/rx_af_cmp.sv
module rx_af_cmp
  import rx_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              first,
  input  logic [2:0]        byte_idx,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              eq_nx
);
  logic       eq_q;
  logic [7:0] ref_byte;

  always_comb begin
    ref_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (int'(byte_idx) == k) ref_byte = ref_addr[k*8 +: 8];
  end

  assign eq_nx = (first ? 1'b1 : eq_q) & (din == ref_byte);

  always_ff @(posedge clk) begin
    if (rst)
      eq_q <= 1'b0;
    else if (step)
      eq_q <= eq_nx;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_af_pkg::*;
#(
  parameter int HASH_W    = 6,
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 12,
  parameter int CRC_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic [7:0]           in_byte,
  input  logic [3:0]           cfg_rx_en,
  input  logic [47:0]          cfg_sta0,
  input  logic [47:0]          cfg_sta1,
  input  logic [(1<<HASH_W)-1:0] cfg_grp_tbl,
  output logic                 addr_valid,
  output logic                 addr_hit,
  output logic                 frame_done,
  output logic                 frame_accept,
  output logic [LEN_W:0]       frame_len
);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LAST_A = LEN_W'(ADDR_BYTES - 1);
  localparam logic [LEN_W:0]   CRC_L  = (LEN_W+1)'(CRC_BYTES);

  logic [LEN_W-1:0]  pos, len_nx;
  logic              step, first, last_addr;
  logic [2:0]        byte_idx;
  logic [HASH_W-1:0] hash_nx;
  logic [NCMP-1:0]   eq_nx;
  logic [ADDR_W-1:0] refs [NCMP];
  logic              mc_q, mc_nx, hit_nx;
  logic              eff_valid, eff_hit, ok;

  rx_af_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .pos(pos), .len_nx(len_nx)
  );

  assign step      = in_valid && (pos <= LAST_A);
  assign first     = (pos == '0);
  assign last_addr = in_valid && (pos == LAST_A);
  assign byte_idx  = pos[2:0];

  rx_af_hash #(.HASH_W(HASH_W)) u_hash (
    .clk(clk), .rst(rst), .step(step), .first(first),
    .byte_idx(byte_idx), .din(in_byte), .hash_nx(hash_nx)
  );

  assign refs[0] = cfg_sta0;
  assign refs[1] = cfg_sta1;
  assign refs[2] = '1;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    rx_af_cmp u_cmp (
      .clk(clk), .rst(rst), .step(step), .first(first),
      .byte_idx(byte_idx), .din(in_byte), .ref_addr(refs[g]),
      .eq_nx(eq_nx[g])
    );
  end

  // group bit of the address: bit 0 of the first byte
  assign mc_nx = first ? in_byte[0] : mc_q;

  assign hit_nx = (cfg_rx_en[EN_STA0]  & eq_nx[0])
                | (cfg_rx_en[EN_STA1]  & eq_nx[1])
                | (cfg_rx_en[EN_BCAST] & eq_nx[2])
                | (cfg_grp_tbl[hash_nx] & (cfg_rx_en[EN_HASHIND] | mc_nx));

  assign eff_valid = !in_sof && (last_addr || addr_valid);
  assign eff_hit   = last_addr ? hit_nx : addr_hit;
  assign ok        = (len_nx >= MIN_L) && eff_valid && eff_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q         <= 1'b0;
      addr_valid   <= 1'b0;
      addr_hit     <= 1'b0;
      frame_done   <= 1'b0;
      frame_accept <= 1'b0;
      frame_len    <= '0;
    end else begin
      if (step && first)
        mc_q <= in_byte[0];
      if (in_valid && in_sof) begin
        addr_valid <= 1'b0;
        addr_hit   <= 1'b0;
      end
      if (last_addr) begin
        addr_valid <= 1'b1;
        addr_hit   <= hit_nx;
      end
      frame_done   <= in_valid && in_eof;
      frame_accept <= in_valid && in_eof && ok;
      frame_len    <= (in_valid && in_eof && ok) ? ({1'b0, len_nx} + CRC_L) : '0;
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 12,
  parameter int CRC_BYTES = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_sof,
  input logic           in_eof,
  input logic           addr_valid,
  input logic           addr_hit,
  input logic           frame_done,
  input logic           frame_accept,
  input logic [LEN_W:0] frame_len
);
  localparam logic [LEN_W:0] MIN_OUT = (LEN_W+1)'(MIN_LEN + CRC_BYTES);

  p_sof_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> !addr_valid);

  p_rise_on_byte_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_valid) |-> $past(in_valid && !in_sof));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(addr_valid) && $stable(addr_hit)));

  p_done_after_eof_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(in_valid && in_eof));

  p_accept_in_done_r9: assert property (@(posedge clk) disable iff (rst)
    frame_accept |-> frame_done);

  p_drop_len_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_accept) |-> (frame_len == '0));

  p_min_len_r8: assert property (@(posedge clk) disable iff (rst)
    frame_accept |-> (frame_len >= MIN_OUT));

  p_accept_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    frame_accept |-> (addr_valid && addr_hit));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .CRC_BYTES(CRC_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .addr_valid(addr_valid), .addr_hit(addr_hit), .frame_done(frame_done),
  .frame_accept(frame_accept), .frame_len(frame_len)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam int LEN_W = 11;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_byte = '0;
  logic [3:0] ctrl = '0;
  logic [47:0] s0 = '0, s1 = '0;
  logic [63:0] tbl = '0;
  logic addr_valid, addr_hit, frame_done, frame_accept;
  logic [LEN_W:0] frame_len;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_byte(in_byte), .cfg_rx_en(ctrl), .cfg_sta0(s0), .cfg_sta1(s1),
    .cfg_grp_tbl(tbl), .addr_valid(addr_valid), .addr_hit(addr_hit),
    .frame_done(frame_done), .frame_accept(frame_accept), .frame_len(frame_len)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fold(logic [47:0] a);
    int h = 0;
    for (int c = 0; c < 8; c++) h ^= int'(a[6*c +: 6]);
    return h;
  endfunction

  function automatic bit model_hit(logic [47:0] a);
    return (ctrl[0] && a == s0) || (ctrl[1] && a == s1) ||
           (ctrl[3] && a == 48'hFFFF_FFFF_FFFF) ||
           (tbl[fold(a)] && (ctrl[2] || a[0]));
  endfunction

  task automatic send(logic [47:0] a, int n, int gap, string req);
    bit eh = model_hit(a);
    bit ea = eh && (n >= 12);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk);
        in_valid = 0;
        repeat (2) @(negedge clk);
      end else
        @(negedge clk);
      if (i == 1) chk({req, " R7 cleared at start"}, addr_valid, 0);
      if (i == 6) begin
        chk({req, " R7 addr_valid"}, addr_valid, 1);
        chk({req, " addr_hit"}, addr_hit, eh);
      end
      in_valid = 1;
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_byte  = (i < 6) ? a[8*i +: 8] : 8'(i * 7 + 3);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    if (n >= 6) begin
      chk({req, " R7 verdict held"}, addr_valid, 1);
      chk({req, " addr_hit at end"}, addr_hit, eh);
    end
    chk({req, " R9 done"}, frame_done, 1);
    chk({req, " accept"}, frame_accept, ea);
    chk({req, " R9 len"}, int'(frame_len), ea ? n + 4 : 0);
    @(negedge clk);
    chk({req, " R9 done pulse"}, frame_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, base;
    logic [47:0] lf = 48'h9A3C_51E7_0B42;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 reset addr_valid", addr_valid, 0);
    chk("R7 reset addr_hit", addr_hit, 0);
    chk("R9 reset done", frame_done, 0);
    chk("R9 reset len", int'(frame_len), 0);

    s0 = 48'h3355_7799_BB10;
    s1 = 48'h0246_8ACE_1357 & ~48'h1;
    // R1
    ctrl = 4'b0001;
    send(s0, 20, 0, "R1 sta0 match");
    send(s0 ^ 48'h0100_0000_0000, 20, 0, "R1 sta0 last byte differs");
    send(s0 ^ 48'h0000_0000_0080, 20, 0, "R1 sta0 first byte differs");
    ctrl = 4'b0000;
    send(s0, 20, 0, "R1 sta0 disabled");
    // R2
    ctrl = 4'b0010;
    send(s1, 16, 0, "R2 sta1 match");
    send(s0, 16, 0, "R2 sta0 not enabled");
    ctrl = 4'b0001;
    send(s1, 16, 0, "R2 sta1 disabled");
    // R3
    ctrl = 4'b1000;
    send(48'hFFFF_FFFF_FFFF, 14, 0, "R3 broadcast");
    ctrl = 4'b0011;
    send(48'hFFFF_FFFF_FFFF, 14, 0, "R3 broadcast disabled");
    // R6
    ctrl = 4'b1011; tbl = '0;
    send(48'h1122_3344_5566, 30, 0, "R6 no source hits");
    // R4 exhaustive over every table entry
    ctrl = 4'b0100;
    base = 48'hA5C3_9E17_4D00;
    for (int k = 0; k < 64; k++) begin
      a = base;
      a[5:0] = 6'(k ^ fold(base));
      tbl = 64'd1 << k;
      send(a, 12, 0, "R4 one-hot entry");
      tbl = ~(64'd1 << k);
      send(a, 12, 0, "R4 complement entry");
    end
    // R5
    tbl = '1; ctrl = 4'b0000;
    send(48'h7788_9900_AA02, 20, 0, "R5 individual ignored");
    send(48'h7788_9900_AA03, 20, 0, "R5 group looked up");
    ctrl = 4'b0100;
    send(48'h7788_9900_AA02, 20, 0, "R5 individual with bit2");
    // R8
    ctrl = 4'b0001; tbl = '0;
    send(s0, 11, 0, "R8 11 bytes");
    send(s0, 12, 0, "R8 12 bytes");
    send(s0, 6, 0, "R8 6 bytes");
    send(s0, 1, 0, "R8 1 byte");
    // R10 stalls inside the address
    ctrl = 4'b0101; tbl = 64'h0123_4567_89AB_CDEF;
    send(s0, 18, 2, "R10 stalled match");
    send(48'h0F0F_0F0F_0F0E, 18, 1, "R10 stalled lookup");
    send(48'h0F0F_0F0F_0F0F, 18, 3, "R10 stalled group");
    // mixed sweep
    for (int j = 0; j < 80; j++) begin
      lf = {lf[46:0], lf[47] ^ lf[46] ^ lf[20] ^ lf[0]};
      tbl  = {lf[31:0], lf[47:16]};
      ctrl = lf[3:0];
      a = lf ^ 48'h5A5A_A5A5_3C3C;
      if (j % 5 == 0) a = s0;
      if (j % 7 == 0) a = s1;
      send(a, 12 + (j % 9), j % 4, "R4 R6 sweep");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule